// File: doc/BRIEF.md
# Dual-Channel Up-Counting Watchdog

This block supervises system software with two watchdog channels that share one register layout and one prescaled time base. A prescaler divides the system clock down to a single-cycle tick, nominally every 10 ms. On each tick, every channel adds one to its 15-bit count. The count is compared against a 15-bit limit that sits in the upper half of the same register. Software keeps a channel quiet by writing its register, which clears the count. If the count is left to reach the limit, the channel expires.

The two channels differ only in what expiry does. The first channel can raise a one-cycle system reset request. The second can hold a level that tells an external switch fabric to discard CPU-bound packets and turn off flow control on all ports. Each action is gated by the top bit of its channel's register. Once a channel expires, its count freezes at the limit and it stays expired until software writes the register again. The reset generator and the packet logic lie outside this block.

Top module: `dual_watchdog`

## Requirements
- R1: Each channel register is 32 bits: bit 31 is the action enable, bits 30:16 the limit, bit 15 always reads 0, and bits 14:0 the live count. Channel 0 decodes at byte offset 0xC0 and channel 1 at 0xC4. Any other offset reads as 0, and writes to it change no channel.
- R2: The time-base tick is high for exactly one clock cycle every TICK_DIV cycles.
- R3: While a channel is not expired and is not being written, its count rises by one on each tick and is otherwise unchanged.
- R4: On a tick where the count already equals the limit, the channel expires. From then on the count holds at the limit.
- R5: A limit of zero makes the channel expire on the first tick after the write, with the count reading 0.
- R6: A write to a channel register loads the enable and limit fields, clears the count to 0, and ends any expiry from the next cycle on. A write takes priority over a tick in the same cycle.
- R7: With its enable set, channel 0 drives `sys_reset_req` high for exactly one cycle, namely the cycle after the expiring tick.
- R8: With its enable set, channel 1 holds `pkt_drop` high from the cycle after the expiring tick until the register is written again.
- R9: With its enable clear, a channel still counts and expires, but its output stays low.
- R10: A write to one channel leaves the other channel's count and fields unchanged.
- R11: After reset, both registers read 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per register write |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_reset_req | output | 1 | One-cycle reset request from channel 0 |
| pkt_drop | output | 1 | Drop/flow-control-off level from channel 1 |

## Verification
The embedded assertions check the following on every cycle:
- the tick is a single-cycle pulse and the prescaler stays in range;
- a channel's count never exceeds its limit and never moves between ticks;
- an expired channel stays frozen until it is written;
- a write clears the count and the expiry;
- the reset request never lasts more than one cycle.

Only the directed scenarios can show the following:
- the exact cycle on which each output rises, measured from the first observed tick;
- the zero-limit case;
- that a disabled action stays silent;
- that the reserved bit and unused offsets read as zero;
- that the channels do not disturb each other.

// File: rtl/dwd_pkg.sv
// Package: shared widths and field positions of the watchdog channel register.
// Assumes a 32-bit register with a 15-bit count and a 15-bit limit.
package dwd_pkg;
    localparam int REG_W   = 32;
    localparam int CNT_W   = 15;
    localparam int EN_BIT  = 31;
    localparam int LIM_LSB = 16;
    localparam int LIM_MSB = LIM_LSB + CNT_W - 1;
    localparam int RSV_BIT = 15;

    typedef struct packed {
        logic             act_en;
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] count;
        logic             expired;
    } chan_state_t;

    // Builds the read image of a channel; the reserved bit is forced to zero.
    function automatic logic [REG_W-1:0] pack_word(input chan_state_t s);
        return {s.act_en, s.limit, 1'b0, s.count};
    endfunction
endpackage

// File: rtl/dwd_tick_gen.sv
// Module: dwd_tick_gen
// Divides the system clock into a one-cycle tick every TICK_DIV cycles.
// Assumes TICK_DIV >= 2. The phase runs freely from reset and is never
// realigned by bus activity.
module dwd_tick_gen #(
    parameter int TICK_DIV = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] phase;

    // Phase counter: wraps to zero after the last cycle of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + PW'(1);
    end

    assign tick = (phase == LAST);

    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);
endmodule

// File: rtl/dwd_channel.sv
// Module: dwd_channel
// One watchdog channel: a count that rises on each tick, freezes once it has
// reached the limit and expires on the next tick, and is cleared by a write.
// PULSE_MODE=1 makes the enabled action a one-cycle pulse; PULSE_MODE=0 makes
// it a level that lasts while the channel is expired.
// Assumes wr_en is already decoded for this channel.
module dwd_channel
    import dwd_pkg::*;
#(
    parameter bit PULSE_MODE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rd_word,
    output logic             act_out
);
    chan_state_t st;
    logic        expire_now;

    // True on the tick that turns a channel sitting at its limit into expired.
    assign expire_now = tick && !wr_en && !st.expired && (st.count == st.limit);

    // Channel state: a write reloads and clears; a tick counts or expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (wr_en) begin
            st.act_en  <= wdata[EN_BIT];
            st.limit   <= wdata[LIM_MSB:LIM_LSB];
            st.count   <= '0;
            st.expired <= 1'b0;
        end else if (tick && !st.expired) begin
            if (st.count == st.limit) st.expired <= 1'b1;
            else                      st.count   <= st.count + CNT_W'(1);
        end
    end

    assign rd_word = pack_word(st);

    generate
        if (PULSE_MODE) begin : g_pulse
            logic pulse_q;
            // Pulse: registered once on the expiring tick when the action is enabled.
            always_ff @(posedge clk) begin
                if (!rst_n) pulse_q <= 1'b0;
                else        pulse_q <= expire_now && st.act_en;
            end
            assign act_out = pulse_q;

            assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
                act_out |=> !act_out);
        end else begin : g_level
            assign act_out = st.act_en && st.expired;
        end
    endgenerate

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st.count <= st.limit || $past(wr_en) == 1'b0 && st.count == '0);
    assert_hold_expired_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st.expired && !wr_en) |=> (st.expired && $stable(st.count)));
    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick) |=> $stable(st.count));
    assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st.count == '0 && !st.expired));
endmodule

// File: rtl/dual_watchdog.sv
// Module: dual_watchdog
// Top of the two-channel watchdog: decodes the register offsets, shares one
// prescaled tick, and routes channel 0 to a reset request pulse and channel 1
// to a packet-drop level.
// Assumes single-cycle write strobes and a combinational read.
module dual_watchdog
    import dwd_pkg::*;
#(
    parameter int              TICK_DIV = 1_000_000,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFF_CH0 = ADDR_W'(8'hC0),
    parameter logic [ADDR_W-1:0] OFF_CH1 = ADDR_W'(8'hC4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              sys_reset_req,
    output logic              pkt_drop
);
    localparam int NCH = 2;
    localparam logic [ADDR_W-1:0] OFFS [NCH] = '{OFF_CH0, OFF_CH1};

    logic             tick;
    logic [NCH-1:0]   wr_sel;
    logic [NCH-1:0]   act;
    logic [REG_W-1:0] words [NCH];

    dwd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign wr_sel[i] = bus_wr_en && (bus_addr == OFFS[i]);
            dwd_channel #(.PULSE_MODE(i == 0)) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .wr_en   (wr_sel[i]),
                .wdata   (bus_wdata),
                .rd_word (words[i]),
                .act_out (act[i])
            );
        end
    endgenerate

    // Read mux: the selected channel image, or zero for an unused offset.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (bus_addr == OFFS[i]) bus_rdata = words[i];
    end

    assign sys_reset_req = act[0];
    assign pkt_drop      = act[1];

    assert_one_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[RSV_BIT] == 1'b0);
endmodule

// File: tb/tb_dual_watchdog.sv
// Directed bench for dual_watchdog, with a short tick period.
module tb_dual_watchdog;
    localparam int DIV = 4;
    localparam logic [7:0] A0 = 8'hC0;
    localparam logic [7:0] A1 = 8'hC4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_reset_req, pkt_drop;

    int n_chk = 0, n_fail = 0, cyc = 0;

    dual_watchdog #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_reset_req(sys_reset_req), .pkt_drop(pkt_drop)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] img(input bit en, input int lim, input int cnt);
        return {en, 15'(lim), 1'b0, 15'(cnt)};
    endfunction

    // Called at a negedge: writes one register on the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    // Waits for the first tick after a write, i.e. the count reading 1.
    task automatic wait_first_tick(input logic [7:0] a);
        logic [31:0] d;
        for (int k = 0; k < DIV + 2; k++) begin
            rd(a, d);
            if (d[14:0] == 15'd1) return;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A0, d); chk(d == 0, "R11 ch0 reset", d, 0);
        rd(A1, d); chk(d == 0, "R11 ch1 reset", d, 0);
        chk(!sys_reset_req && !pkt_drop, "R11 outputs", {sys_reset_req, pkt_drop}, 0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        wr(A0, 32'h8007_FFFF);
        rd(A0, d); chk(d == img(1, 7, 0), "R1 R6 readback", d, img(1, 7, 0));
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); chk(d == 0, "R1 unused offset", d, 0);
        rd(A0, d); chk(d[31:15] == img(1, 7, 0) >> 15, "R1 unused write ignored", d, img(1, 7, 0));
        wr(A0, 32'h0);
    endtask

    task automatic t_drop();
        logic [31:0] d; int lim = 5;
        wr(A1, img(1, lim, 0));
        wait_first_tick(A1);
        repeat (DIV - 1) @(negedge clk);
        rd(A1, d); chk(d[14:0] == 1, "R3 no change between ticks", d, 1);
        @(negedge clk);
        rd(A1, d); chk(d[14:0] == 2, "R2 R3 next tick", d, 2);
        repeat ((lim - 1) * DIV - 1) @(negedge clk);
        chk(pkt_drop == 0, "R8 not yet", pkt_drop, 0);
        rd(A1, d); chk(d[14:0] == lim, "R4 count at limit", d, lim);
        @(negedge clk);
        chk(pkt_drop == 1, "R8 drop rises", pkt_drop, 1);
        repeat (3 * DIV) @(negedge clk);
        chk(pkt_drop == 1, "R8 drop held", pkt_drop, 1);
        rd(A1, d); chk(d[14:0] == lim, "R4 count frozen", d, lim);
        wr(A1, img(0, 9, 0));
        chk(pkt_drop == 0, "R6 write ends expiry", pkt_drop, 0);
        rd(A1, d); chk(d == img(0, 9, 0), "R6 count cleared", d, img(0, 9, 0));
    endtask

    task automatic t_reset_pulse();
        logic [31:0] d; int lim = 3; int hi = 0;
        wr(A0, img(1, lim, 0));
        wait_first_tick(A0);
        repeat (lim * DIV - 1) @(negedge clk);
        chk(sys_reset_req == 0, "R7 before expiry", sys_reset_req, 0);
        @(negedge clk);
        chk(sys_reset_req == 1, "R7 pulse", sys_reset_req, 1);
        for (int k = 0; k < 4 * DIV; k++) begin
            @(negedge clk);
            if (sys_reset_req) hi++;
        end
        chk(hi == 0, "R7 single cycle", hi, 0);
        rd(A0, d); chk(d[14:0] == lim, "R4 ch0 frozen", d, lim);
    endtask

    task automatic t_disabled();
        logic [31:0] d; int hi = 0;
        wr(A0, img(0, 2, 0));
        for (int k = 0; k < 6 * DIV; k++) begin
            @(negedge clk);
            if (sys_reset_req) hi++;
        end
        chk(hi == 0, "R9 no pulse when disabled", hi, 0);
        rd(A0, d); chk(d == img(0, 2, 2), "R9 still counts to limit", d, img(0, 2, 2));
    endtask

    task automatic t_zero();
        logic [31:0] d; int seen = -1;
        wr(A1, img(1, 0, 0));
        for (int k = 1; k <= DIV + 1 && seen < 0; k++) begin
            @(negedge clk);
            if (pkt_drop) seen = k;
        end
        chk(seen >= 1 && seen <= DIV, "R5 zero limit expires on first tick", seen, DIV);
        rd(A1, d); chk(d == img(1, 0, 0), "R5 count stays 0", d, img(1, 0, 0));
        wr(A1, img(0, 0, 0));
    endtask

    task automatic t_indep();
        logic [31:0] d, e;
        wr(A1, img(0, 100, 0));
        repeat (5 * DIV) @(negedge clk);
        rd(A1, e);
        wr(A0, img(1, 50, 0));
        rd(A1, d);
        chk(d[31:15] == e[31:15] && d[14:0] >= e[14:0] && d[14:0] != 0,
            "R10 ch1 unaffected", d, e);
        wr(A0, img(0, 50, 0));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_drop();
        t_reset_pulse();
        t_disabled();
        t_zero();
        t_indep();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule